// File: doc/BRIEF.md
# Chunk Signature Conflict Detector

This block holds a pair of hashed address signatures for every core of a multicore cluster. One signature collects the lines the core has read during its current chunk of execution, and the other collects the lines it has written. Each core reports its memory accesses as cache-line addresses and signals every retired instruction. Once a core has retired a fixed number of instructions, it raises a commit request. A round-robin arbiter lets one chunk commit per cycle, so every core sees the same total order of commits.

In the cycle a chunk commits, the committing core's write signature is broadcast to all other cores. Each other core ANDs that signature with its own read signature and, separately, with its own write signature. If either product has a set bit in every bank, the receiving core's chunk is squashed. Commit and squash both empty the affected core's signatures and restart its chunk.

Software can suspend and resume address collection for each core with explicit begin and end strobes. Squash is only reported on an output pin. Restoring core state is left to the surrounding logic.

Top module: `chunk_sig_detector`

## Requirements
- R1: After reset, all signatures are empty, every instruction counter is zero, collection is enabled on every core, and chunk_req, commit_grant and squash are all zero.
- R2: A collected access sets one bit in each of the 4 banks (64 bits each) of the core's read signature (load) or write signature (store). These bits are visible from the next cycle. The bank b bit index is obtained by rotating the 26-bit line address left by 5*b, then XORing bit k of the result into index bit k mod 6.
- R3: While core g holds the grant, another core i is squashed in that same cycle when, for its read signature or for its write signature, the AND with core g's write signature is non-zero in all four banks. Without a grant, no squash is raised.
- R4: Each retire pulse increments a core's counter. chunk_req is high exactly while the counter equals CHUNK_LEN. Retire pulses arriving while the request is up are ignored.
- R5: At most one grant is active per cycle. The grant goes to the first requesting core after the last granted core, in ascending index order with wrap-around. Whenever any request is up, a grant is given. Core 0 has the highest priority after reset.
- R6: A commit or squash clears that core's signatures and counter at the end of the cycle. Any access or retire pulse in that cycle is discarded.
- R7: A squashed core never holds the grant in the same cycle, and its request is withdrawn from the next cycle.
- R8: An end strobe disables collection from the next cycle and a begin strobe re-enables it. End wins if both arrive together. Accesses made while collection is disabled leave the signatures unchanged. The collection setting survives commits and squashes.
- R9: The conflict outcome depends only on the set of accesses in a chunk, not on the order in which loads and stores arrive.
- R10: A committing core is never squashed by its own broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | NC | Per-core access strobe |
| acc_store | input | NC | Per-core access kind: 1 = store, 0 = load |
| acc_line | input | NC*LINE_W | Per-core cache-line address, core i at bits [i*LINE_W +: LINE_W] |
| retire | input | NC | Per-core instruction retired pulse |
| collect_begin | input | NC | Per-core strobe re-enabling address collection |
| collect_end | input | NC | Per-core strobe suspending address collection |
| chunk_req | output | NC | Per-core commit request (instruction limit reached) |
| commit_grant | output | NC | One-hot commit grant |
| squash | output | NC | Per-core squash of the current chunk |

## Verification
The three outputs are combinational functions of registered state, so each is due in the first cycle its state allows. chunk_req rises in the cycle after the CHUNK_LEN-th retire pulse. The grant appears in that same cycle if the arbiter picks the core. A squash appears in the grant cycle of the conflicting commit. The effects of an access show up only through a squash at a later commit.

The bench drives inputs on the falling edge and compares all three output vectors there against a behavioural model that is advanced once per rising edge. Every due value is therefore checked in exactly the cycle it is due. Directed checks wait for a named grant, then compare squash and request in that cycle and in the one after.

// File: rtl/chunk_sig_pkg.sv
// Package: shared types for the chunk signature conflict detector.
// Assumes nothing beyond SystemVerilog 2017 enums.
package chunk_sig_pkg;

    // Kind of address insertion a core performs in a cycle.
    typedef enum logic [1:0] {
        INS_NONE  = 2'd0,
        INS_LOAD  = 2'd1,
        INS_STORE = 2'd2
    } ins_kind_e;

    // Defaults shared by the modules of the block.
    localparam int DEF_LINE_W = 26;
    localparam int DEF_NBANK  = 4;
    localparam int DEF_BANK_W = 64;
    localparam int DEF_SKEW   = 5;

endpackage

// File: rtl/sig_hash.sv
// Module: sig_hash
// Maps a cache-line address to one set bit per signature bank.
// Bank b rotates the line address left by b*SKEW (mod LINE_W), then
// XOR-folds it into an index of log2(BANK_W) bits: bit k of the
// rotated value goes into index bit k mod IDX_W.
// Assumes BANK_W is a power of two and SKEW*NBANK stays meaningful
// against LINE_W. Purely combinational.
module sig_hash #(
    parameter int LINE_W = chunk_sig_pkg::DEF_LINE_W,
    parameter int NBANK  = chunk_sig_pkg::DEF_NBANK,
    parameter int BANK_W = chunk_sig_pkg::DEF_BANK_W,
    parameter int SKEW   = chunk_sig_pkg::DEF_SKEW
) (
    input  logic [LINE_W-1:0]       line,
    output logic [NBANK*BANK_W-1:0] bits
);
    localparam int IDX_W = $clog2(BANK_W);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int ROT = (b * SKEW) % LINE_W;
        logic [LINE_W-1:0] rot;
        logic [IDX_W-1:0]  idx;
        logic [BANK_W-1:0] dec;

        // Per-bank skew so each bank sees a different address slice.
        if (ROT == 0) begin : g_norot
            assign rot = line;
        end else begin : g_rot
            assign rot = {line[LINE_W-1-ROT:0], line[LINE_W-1:LINE_W-ROT]};
        end

        // XOR-fold the rotated line address into the bank index.
        always_comb begin
            idx = '0;
            for (int k = 0; k < LINE_W; k++) begin
                idx[k % IDX_W] = idx[k % IDX_W] ^ rot[k];
            end
        end

        // Decode the index into a one-hot bank vector.
        always_comb begin
            dec = '0;
            dec[idx] = 1'b1;
        end

        assign bits[b*BANK_W +: BANK_W] = dec;
    end
endmodule

// File: rtl/commit_arbiter.sv
// Module: commit_arbiter
// Round-robin arbiter that grants one chunk commit per cycle.
// The search starts at the core after the last granted one. After
// reset, core 0 is searched first. The grant is combinational from
// the requests; only the pointer is stored. Assumes N >= 2.
module commit_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int PTR_W = $clog2(N);

    logic [PTR_W-1:0] last_q;
    logic [PTR_W-1:0] win_idx;
    logic             win_any;

    // Pick the first requester after the last winner, wrapping.
    always_comb begin
        grant   = '0;
        win_idx = last_q;
        win_any = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int j;
            j = (int'(last_q) + off) % N;
            if (!win_any && req[j]) begin
                grant[j] = 1'b1;
                win_idx  = PTR_W'(j);
                win_any  = 1'b1;
            end
        end
    end

    // Remember the winner so the next search starts after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= PTR_W'(N - 1);
        end else if (win_any) begin
            last_q <= win_idx;
        end
    end
endmodule

// File: rtl/core_sig_unit.sv
// Module: core_sig_unit
// State of one core's chunk: its read and write signatures, its
// retired-instruction counter and its collection enable. Raises a
// commit request at the instruction limit. Tests a broadcast write
// signature against both of its own signatures and squashes on a
// hit in every bank. Commit or squash empties the chunk at the next
// edge. Assumes the broadcast is valid only while another core
// holds the grant.
module core_sig_unit #(
    parameter int LINE_W    = chunk_sig_pkg::DEF_LINE_W,
    parameter int NBANK     = chunk_sig_pkg::DEF_NBANK,
    parameter int BANK_W    = chunk_sig_pkg::DEF_BANK_W,
    parameter int SKEW      = chunk_sig_pkg::DEF_SKEW,
    parameter int CHUNK_LEN = 2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic                    acc_store,
    input  logic [LINE_W-1:0]       acc_line,
    input  logic                    retire,
    input  logic                    col_begin,
    input  logic                    col_end,
    input  logic                    grant_me,
    input  logic                    grant_other,
    input  logic [NBANK*BANK_W-1:0] bcast_wsig,
    output logic [NBANK*BANK_W-1:0] own_wsig,
    output logic                    req,
    output logic                    squash
);
    import chunk_sig_pkg::*;

    localparam int SIG_W = NBANK * BANK_W;
    localparam int CNT_W = $clog2(CHUNK_LEN + 1);

    logic [SIG_W-1:0] rsig_q, wsig_q;
    logic [SIG_W-1:0] ins_bits;
    logic [CNT_W-1:0] cnt_q;
    logic             collect_q;
    logic [NBANK-1:0] bank_hit_r, bank_hit_w;
    logic             conflict;
    logic             chunk_end;
    ins_kind_e        kind;

    sig_hash #(
        .LINE_W (LINE_W),
        .NBANK  (NBANK),
        .BANK_W (BANK_W),
        .SKEW   (SKEW)
    ) u_hash (
        .line (acc_line),
        .bits (ins_bits)
    );

    // Classify this cycle's insertion; nothing when collection is off.
    always_comb begin
        if (!acc_valid || !collect_q) kind = INS_NONE;
        else if (acc_store)           kind = INS_STORE;
        else                          kind = INS_LOAD;
    end

    // Per-bank non-empty test of the broadcast against both signatures.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_hit_r[b] = |(bcast_wsig[b*BANK_W +: BANK_W] & rsig_q[b*BANK_W +: BANK_W]);
        assign bank_hit_w[b] = |(bcast_wsig[b*BANK_W +: BANK_W] & wsig_q[b*BANK_W +: BANK_W]);
    end

    assign conflict  = (&bank_hit_r) | (&bank_hit_w);
    assign squash    = grant_other & ~grant_me & conflict;
    assign chunk_end = grant_me | squash;
    assign req       = (cnt_q == CNT_W'(CHUNK_LEN));
    assign own_wsig  = wsig_q;

    // Accumulate addresses into the signatures; empty them at chunk end.
    always_ff @(posedge clk) begin
        if (!rst_n || chunk_end) begin
            rsig_q <= '0;
            wsig_q <= '0;
        end else begin
            case (kind)
                INS_LOAD:  rsig_q <= rsig_q | ins_bits;
                INS_STORE: wsig_q <= wsig_q | ins_bits;
                default:   ;
            endcase
        end
    end

    // Count retired instructions up to the chunk limit.
    always_ff @(posedge clk) begin
        if (!rst_n || chunk_end) begin
            cnt_q <= '0;
        end else if (retire && !req) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Collection enable: end strobe wins, survives chunk boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collect_q <= 1'b1;
        end else if (col_end) begin
            collect_q <= 1'b0;
        end else if (col_begin) begin
            collect_q <= 1'b1;
        end
    end
endmodule

// File: rtl/chunk_sig_detector.sv
// Module: chunk_sig_detector (top)
// Instantiates one signature unit per core and the commit arbiter.
// Drives the granted core's write signature onto a shared broadcast
// so every other unit can test it for a conflict in the grant cycle.
// Assumes NC >= 2 and that each core's acc_line carries a
// cache-line address.
module chunk_sig_detector #(
    parameter int NC        = 4,
    parameter int LINE_W    = chunk_sig_pkg::DEF_LINE_W,
    parameter int NBANK     = chunk_sig_pkg::DEF_NBANK,
    parameter int BANK_W    = chunk_sig_pkg::DEF_BANK_W,
    parameter int SKEW      = chunk_sig_pkg::DEF_SKEW,
    parameter int CHUNK_LEN = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NC-1:0]        acc_valid,
    input  logic [NC-1:0]        acc_store,
    input  logic [NC*LINE_W-1:0] acc_line,
    input  logic [NC-1:0]        retire,
    input  logic [NC-1:0]        collect_begin,
    input  logic [NC-1:0]        collect_end,
    output logic [NC-1:0]        chunk_req,
    output logic [NC-1:0]        commit_grant,
    output logic [NC-1:0]        squash
);
    localparam int SIG_W = NBANK * BANK_W;

    logic [NC-1:0][SIG_W-1:0] wsig_all;
    logic [SIG_W-1:0]         bcast;
    logic                     any_grant;

    commit_arbiter #(.N(NC)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (chunk_req),
        .grant (commit_grant)
    );

    assign any_grant = |commit_grant;

    // Select the committing core's write signature for broadcast.
    always_comb begin
        bcast = '0;
        for (int i = 0; i < NC; i++) begin
            if (commit_grant[i]) bcast = bcast | wsig_all[i];
        end
    end

    for (genvar i = 0; i < NC; i++) begin : g_core
        core_sig_unit #(
            .LINE_W    (LINE_W),
            .NBANK     (NBANK),
            .BANK_W    (BANK_W),
            .SKEW      (SKEW),
            .CHUNK_LEN (CHUNK_LEN)
        ) u_core (
            .clk         (clk),
            .rst_n       (rst_n),
            .acc_valid   (acc_valid[i]),
            .acc_store   (acc_store[i]),
            .acc_line    (acc_line[i*LINE_W +: LINE_W]),
            .retire      (retire[i]),
            .col_begin   (collect_begin[i]),
            .col_end     (collect_end[i]),
            .grant_me    (commit_grant[i]),
            .grant_other (any_grant),
            .bcast_wsig  (bcast),
            .own_wsig    (wsig_all[i]),
            .req         (chunk_req[i]),
            .squash      (squash[i])
        );
    end
endmodule

// File: rtl/chunk_sig_checker.sv
// Module: chunk_sig_checker
// Protocol checks on the request, grant and squash outputs of the
// detector, bound to every instance of the top module.
module chunk_sig_checker #(
    parameter int NC = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NC-1:0] chunk_req,
    input logic [NC-1:0] commit_grant,
    input logic [NC-1:0] squash
);
    // R5: never more than one commit in a cycle.
    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_grant));

    // R5: a pending request is always served by some grant.
    a_r5_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (|chunk_req) |-> (|commit_grant));

    // R3: squashes only happen while a chunk commits.
    a_r3_squash_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (|squash) |-> (|commit_grant));

    for (genvar i = 0; i < NC; i++) begin : g_core
        // R4: only a requesting core is granted.
        a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
            commit_grant[i] |-> chunk_req[i]);

        // R6: a committed chunk restarts with an empty counter.
        a_r6_req_drops_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
            commit_grant[i] |=> !chunk_req[i]);

        // R7: a squashed core is not granted in the same cycle.
        a_r7_no_grant_when_squashed: assert property (@(posedge clk) disable iff (!rst_n)
            squash[i] |-> !commit_grant[i]);

        // R7: a squashed core's request is withdrawn.
        a_r7_squash_withdraws_req: assert property (@(posedge clk) disable iff (!rst_n)
            squash[i] |=> !chunk_req[i]);
    end
endmodule

bind chunk_sig_detector chunk_sig_checker #(.NC(NC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chunk_req    (chunk_req),
    .commit_grant (commit_grant),
    .squash       (squash)
);

// File: tb/sim_chunk_sig_detector.sv
module sim_chunk_sig_detector;
    localparam int NC  = 4;
    localparam int LW  = 26;
    localparam int LEN = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC-1:0]    d_valid, d_store, d_ret, d_beg, d_end;
    logic [NC*LW-1:0] d_line;
    logic [NC-1:0]    chunk_req, commit_grant, squash;

    int total = 0;
    int bad   = 0;

    // Behavioural reference model state.
    logic [255:0] m_r [NC];
    logic [255:0] m_w [NC];
    int           m_cnt [NC];
    bit           m_col [NC];
    int           m_last;

    always #2.5 clk = ~clk;

    chunk_sig_detector #(.NC(NC), .CHUNK_LEN(LEN)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid     (d_valid),
        .acc_store     (d_store),
        .acc_line      (d_line),
        .retire        (d_ret),
        .collect_begin (d_beg),
        .collect_end   (d_end),
        .chunk_req     (chunk_req),
        .commit_grant  (commit_grant),
        .squash        (squash)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Signature bits for one line: rotate left by 5*b, fold mod 6.
    function automatic logic [255:0] hbits(input logic [LW-1:0] line);
        logic [255:0] v;
        v = '0;
        for (int b = 0; b < 4; b++) begin
            logic [LW-1:0] rot;
            int idx;
            for (int k = 0; k < LW; k++) rot[(k + 5*b) % LW] = line[k];
            idx = 0;
            for (int k = 0; k < LW; k++) if (rot[k]) idx = idx ^ (1 << (k % 6));
            v[b*64 + idx] = 1'b1;
        end
        return v;
    endfunction

    function automatic bit all_banks(input logic [255:0] a, input logic [255:0] c);
        logic [255:0] p;
        p = a & c;
        for (int b = 0; b < 4; b++) if (p[b*64 +: 64] == '0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic clear_drive();
        d_valid = '0; d_store = '0; d_ret = '0; d_beg = '0; d_end = '0; d_line = '0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NC; i++) begin
            m_r[i] = '0; m_w[i] = '0; m_cnt[i] = 0; m_col[i] = 1'b1;
        end
        m_last = NC - 1;
    endtask

    // Compare the outputs with the model, advance the model, cross one edge.
    task automatic step();
        logic [NC-1:0] eg, es, er;
        int g;
        eg = '0; es = '0; er = '0; g = -1;
        for (int i = 0; i < NC; i++) er[i] = (m_cnt[i] == LEN);
        for (int off = 1; off <= NC; off++) begin
            int j;
            j = (m_last + off) % NC;
            if (g < 0 && er[j]) g = j;
        end
        if (g >= 0) begin
            eg[g] = 1'b1;
            for (int i = 0; i < NC; i++)
                if (i != g && (all_banks(m_w[g], m_r[i]) || all_banks(m_w[g], m_w[i]))) es[i] = 1'b1;
        end
        chk(commit_grant == eg, "R5 grant", int'(commit_grant), int'(eg));
        chk(squash == es, "R3 squash", int'(squash), int'(es));
        chk(chunk_req == er, "R4 request", int'(chunk_req), int'(er));
        for (int i = 0; i < NC; i++) begin
            if (eg[i] || es[i]) begin
                m_r[i] = '0; m_w[i] = '0; m_cnt[i] = 0;
            end else begin
                if (m_col[i] && d_valid[i]) begin
                    if (d_store[i]) m_w[i] = m_w[i] | hbits(d_line[i*LW +: LW]);
                    else            m_r[i] = m_r[i] | hbits(d_line[i*LW +: LW]);
                end
                if (d_ret[i] && m_cnt[i] < LEN) m_cnt[i]++;
            end
            if (d_end[i]) m_col[i] = 1'b0;
            else if (d_beg[i]) m_col[i] = 1'b1;
        end
        if (g >= 0) m_last = g;
        @(posedge clk);
        @(negedge clk);
        clear_drive();
    endtask

    task automatic acc(input int c, input bit st, input logic [LW-1:0] line);
        d_valid[c] = 1'b1;
        d_store[c] = st;
        d_line[c*LW +: LW] = line;
    endtask

    task automatic retire_steps(input logic [NC-1:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            d_ret = mask;
            step();
        end
    endtask

    task automatic wait_grant(input int c);
        int k;
        k = 0;
        while (!commit_grant[c] && k < 20) begin
            step();
            k++;
        end
        chk(commit_grant[c] == 1'b1, "R5 expected grant", int'(commit_grant), 1 << c);
    endtask

    localparam logic [LW-1:0] LA = 26'h0001234;
    localparam logic [LW-1:0] LB = 26'h2a5c001;
    localparam logic [LW-1:0] LC = 26'h1f00f0e;
    localparam logic [LW-1:0] LD = 26'h0777777;

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_drive();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk(chunk_req == '0 && commit_grant == '0 && squash == '0, "R1 reset outputs",
            int'({chunk_req, commit_grant, squash}), 0);

        // R2, R3, R10: store and load of the same line conflict.
        acc(0, 1'b1, LA);
        acc(1, 1'b0, LA);
        step();
        retire_steps(4'b0001, LEN);
        wait_grant(0);
        chk(squash == 4'b0010, "R3 read hit squashes reader", int'(squash), 2);
        chk(squash[0] == 1'b0, "R10 committer not self-squashed", int'(squash[0]), 0);
        chk(squash[1] == 1'b1, "R2 load bits landed in read signature", int'(squash[1]), 1);
        step();

        // R8: core 1 loads with collection off; core 2 loads an unrelated line.
        d_end[1] = 1'b1;
        step();
        acc(1, 1'b0, LB);
        acc(2, 1'b0, LC);
        step();
        acc(0, 1'b1, LB);
        step();
        retire_steps(4'b0001, LEN);
        wait_grant(0);
        chk(squash == 4'b0000, "R8 uncollected load causes no squash", int'(squash), 0);
        d_beg[1] = 1'b1;
        step();

        // R9: opposite insertion orders, same outcome.
        acc(1, 1'b0, LA); acc(2, 1'b0, LB); acc(3, 1'b1, LA);
        step();
        acc(1, 1'b0, LB); acc(2, 1'b0, LA); acc(3, 1'b1, LB);
        step();
        retire_steps(4'b1000, LEN);
        wait_grant(3);
        chk(squash == 4'b0110, "R9 order independent", int'(squash), 6);
        step();

        // R6: access and retire in the commit cycle are discarded.
        retire_steps(4'b0001, LEN);
        wait_grant(0);
        acc(0, 1'b1, LC);
        d_ret[0] = 1'b1;
        step();
        acc(2, 1'b0, LC);
        step();
        retire_steps(4'b0001, LEN - 1);
        chk(chunk_req[0] == 1'b0, "R6 counter restarted", int'(chunk_req[0]), 0);
        retire_steps(4'b0001, 1);
        chk(commit_grant[0] == 1'b1, "R6 commit after full chunk", int'(commit_grant), 1);
        chk(squash == 4'b0000, "R6 dropped store left no bits", int'(squash), 0);
        step();

        // R7: two writers of one line request together; loser is squashed.
        acc(1, 1'b1, LD); acc(2, 1'b1, LD);
        step();
        retire_steps(4'b0110, LEN);
        begin
            int w, l;
            w = commit_grant[1] ? 1 : 2;
            l = 3 - w;
            chk(commit_grant[1] ^ commit_grant[2], "R7 one of the two granted", int'(commit_grant), 0);
            chk(squash[l] == 1'b1 && commit_grant[l] == 1'b0, "R7 loser squashed, not granted",
                int'(squash), 1 << l);
            step();
            chk(chunk_req[l] == 1'b0 && commit_grant[l] == 1'b0, "R7 request withdrawn",
                int'(chunk_req), 0);
        end
        step();

        // R5: all cores request at once; each is granted once in rotation.
        retire_steps(4'b1111, LEN);
        begin
            logic [NC-1:0] seen;
            seen = '0;
            for (int k = 0; k < NC; k++) begin
                seen = seen | commit_grant;
                step();
            end
            chk(seen == 4'b1111, "R5 every requester served", int'(seen), 15);
        end

        // R2 R3 R4 R5 R9: random traffic against the model.
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < NC; i++) begin
                if ($urandom_range(0, 2) != 0) begin
                    logic [LW-1:0] ln;
                    ln = ($urandom_range(0, 3) == 0) ? LW'($urandom) : LW'($urandom_range(0, 7));
                    acc(i, 1'($urandom_range(0, 1)), ln);
                end
                d_ret[i] = 1'($urandom_range(0, 1));
                d_end[i] = ($urandom_range(0, 40) == 0);
                d_beg[i] = ($urandom_range(0, 10) == 0);
            end
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule